// File: doc/BRIEF.md
# Shared Multiply-Add Channel Calibration Engine

This block keeps the trim state for a forty-channel converter and produces each channel's calibrated code. Every channel owns two raw input words (bank A and bank B), a gain word and an offset word. It also owns two calibrated result words, one per bank. A host writes through a single register port that carries a channel number, a register select and a 14-bit data word. One global bank bit, set through the same port, decides which bank a data write lands in. It also decides which bank a gain or offset write recalculates.

Each accepted write marks the affected channel and bank as pending. A single time-shared multiply-add pipeline drains the pending set one entry per cycle. It computes `x * (gain + 1) / 2^14 + offset - 2^13`, clamps the result to 0..16383, and stores it in the calibrated word. The calibrated words cannot be written by the host. They change only when the pipeline writes one back. A read-back port returns any channel's calibrated word for either bank, and a busy output shows that work is still queued or in flight.

Top module: `cal_engine`

## Requirements
- R1: After reset, every channel reads back 8192 in both banks, `busy` is low, the bank bit is 0, every gain is 16383, every offset is 8192 and every input is 8192.
- R2: A recalculated word equals floor(x*(gain+1)/16384) + offset - 8192, held at 0 when negative and at 16383 when larger. It never wraps.
- R3: `wr_sel` = 0 writes input data. Bank bit 0 stores it in input A and recalculates only bank A. Bank bit 1 stores it in input B and recalculates only bank B.
- R4: `wr_sel` = 1 (gain) and `wr_sel` = 2 (offset) update the channel's shared gain or offset word. They recalculate only the bank chosen by the bank bit, using that bank's input.
- R5: With the engine idle, a write accepted at clock edge k shows its result on the read-back port after edge k+2. `busy` is high after edges k and k+1 and low after edge k+2.
- R6: Writes to different channels on consecutive cycles are all serviced by the one shared pipeline. `busy` stays high until the last of them has been written back, and every channel then holds its own correct result.
- R7: If a channel is written in the same cycle that its pending recalculation is taken into the pipeline, the stale result is stored first. The entry is then recalculated once more, so the final value reflects the newest data.
- R8: A write with `wr_ch` >= 40 is ignored and queues no work. `wr_sel` = 3 sets the bank bit to `wr_data[0]` and queues no work.
- R9: The calibrated word of a channel and bank that no recalculation touches keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_ch | input | 6 | Channel addressed by the write |
| wr_sel | input | 2 | 0 data, 1 gain, 2 offset, 3 bank bit |
| wr_data | input | 14 | Write data word |
| rd_ch | input | 6 | Channel for read-back |
| rd_bank | input | 1 | Bank for read-back (0 = A, 1 = B) |
| rd_data | output | 14 | Calibrated word of the selected channel and bank |
| busy | output | 1 | Recalculation pending or in flight |

## Verification
Two things can coincide in one cycle: a host write to a channel, and the start of that same channel's queued recalculation. The pipeline then captures the old operands, and the new write re-marks the entry. The bench provokes this by writing channel 30 twice on consecutive cycles, so the second write lands exactly on the edge where the first enters the pipeline. It judges the outcome cycle by cycle. The read-back must show the first value after the second edge, with `busy` still high. It must show the second value one edge later, with `busy` low.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_GAIN = 2'd1,
        SEL_OFFS = 2'd2,
        SEL_CTRL = 2'd3
    } wsel_e;

endpackage

// File: rtl/cal_store.sv
// Holds raw inputs, gain and offset words plus the global bank bit.
// Emits one pending request per accepted trim-affecting write.
module cal_store #(
    parameter int NUM_CH = 40,
    parameter int DW     = 14,
    localparam int CW    = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_ch,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] op_ch,
    input  logic          op_bank,
    output logic [DW-1:0] op_x,
    output logic [DW-1:0] op_m,
    output logic [DW-1:0] op_c,
    output logic          req_vld,
    output logic [CW:0]   req_idx
);
    import cal_pkg::*;

    localparam logic [CW:0]   NCH = NUM_CH[CW:0];
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] in_a;
        logic [NUM_CH-1:0][DW-1:0] in_b;
        logic [NUM_CH-1:0][DW-1:0] gain;
        logic [NUM_CH-1:0][DW-1:0] offs;
        logic                      bank;
    } st_t;

    st_t st_d, st_q;
    logic in_range;

    always_comb begin
        st_d     = st_q;
        req_vld  = 1'b0;
        req_idx  = {wr_ch, st_q.bank};
        in_range = ({1'b0, wr_ch} < NCH);
        if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_CTRL: st_d.bank = wr_data[0];
                SEL_DATA: if (in_range) begin
                    if (st_q.bank) st_d.in_b[wr_ch] = wr_data;
                    else           st_d.in_a[wr_ch] = wr_data;
                    req_vld = 1'b1;
                end
                SEL_GAIN: if (in_range) begin
                    st_d.gain[wr_ch] = wr_data;
                    req_vld = 1'b1;
                end
                SEL_OFFS: if (in_range) begin
                    st_d.offs[wr_ch] = wr_data;
                    req_vld = 1'b1;
                end
            endcase
        end
        op_x = op_bank ? st_q.in_b[op_ch] : st_q.in_a[op_ch];
        op_m = st_q.gain[op_ch];
        op_c = st_q.offs[op_ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.in_a <= {NUM_CH{MID}};
            st_q.in_b <= {NUM_CH{MID}};
            st_q.gain <= {NUM_CH{{DW{1'b1}}}};
            st_q.offs <= {NUM_CH{MID}};
            st_q.bank <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cal_queue.sv
// Pending set of (channel, bank) entries; issues the lowest index each cycle.
module cal_queue #(
    parameter int NUM_CH = 40,
    localparam int IW    = $clog2(NUM_CH) + 1,
    localparam int NP    = 2 * NUM_CH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_vld,
    input  logic [IW-1:0] set_idx,
    output logic          iss_vld,
    output logic [IW-1:0] iss_idx,
    output logic          pend_any
);
    typedef struct packed {
        logic [NP-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        iss_vld = 1'b0;
        iss_idx = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (st_q.pend[i]) begin
                iss_vld = 1'b1;
                iss_idx = IW'(i);
            end
        end
        if (iss_vld) st_d.pend[iss_idx] = 1'b0;
        if (set_vld) st_d.pend[set_idx] = 1'b1;
        pend_any = |st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cal_datapath.sv
// Shared multiply-add: operand capture stage, then compute and clamp.
module cal_datapath #(
    parameter int DW  = 14,
    parameter int CW  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_vld,
    input  logic [CW-1:0] iss_ch,
    input  logic          iss_bank,
    input  logic [DW-1:0] op_x,
    input  logic [DW-1:0] op_m,
    input  logic [DW-1:0] op_c,
    output logic          wb_vld,
    output logic [CW-1:0] wb_ch,
    output logic          wb_bank,
    output logic [DW-1:0] wb_data
);
    localparam int SW = DW + 3;
    localparam logic signed [SW-1:0] HALFS = SW'(1 << (DW - 1));
    localparam logic signed [SW-1:0] MAXS  = SW'((1 << DW) - 1);

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] ch;
        logic          bank;
        logic [DW-1:0] x;
        logic [DW-1:0] m;
        logic [DW-1:0] c;
    } st_t;

    st_t st_d, st_q;
    logic [DW:0]            m1;
    logic [2*DW:0]          prod;
    logic [DW:0]            scaled;
    logic signed [SW-1:0]   sum;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = iss_vld;
        if (iss_vld) begin
            st_d.ch   = iss_ch;
            st_d.bank = iss_bank;
            st_d.x    = op_x;
            st_d.m    = op_m;
            st_d.c    = op_c;
        end
        m1     = {1'b0, st_q.m} + {{DW{1'b0}}, 1'b1};
        prod   = {{(DW+1){1'b0}}, st_q.x} * {{DW{1'b0}}, m1};
        scaled = (DW+1)'(prod >> DW);
        sum    = $signed({2'b00, scaled}) + $signed({3'b000, st_q.c}) - HALFS;
        if (sum[SW-1])      wb_data = '0;
        else if (sum > MAXS) wb_data = '1;
        else                wb_data = sum[DW-1:0];
        wb_vld  = st_q.vld;
        wb_ch   = st_q.ch;
        wb_bank = st_q.bank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cal_engine.sv
// Top: calibrated result storage, read-back and busy indication.
module cal_engine #(
    parameter int NUM_CH = 40,
    parameter int DW     = 14,
    localparam int CW    = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_ch,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] rd_ch,
    input  logic          rd_bank,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    localparam logic [CW:0]   NCH = NUM_CH[CW:0];
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] cal_a;
        logic [NUM_CH-1:0][DW-1:0] cal_b;
    } st_t;

    st_t st_d, st_q;

    logic          req_vld;
    logic [CW:0]   req_idx;
    logic          iss_vld;
    logic [CW:0]   iss_idx;
    logic          pend_any;
    logic [DW-1:0] op_x, op_m, op_c;
    logic          wb_vld;
    logic [CW-1:0] wb_ch;
    logic          wb_bank;
    logic [DW-1:0] wb_data;
    logic [NUM_CH-1:0][DW-1:0] cal_a_w, cal_b_w;

    cal_store #(.NUM_CH(NUM_CH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
        .op_ch(iss_idx[CW:1]), .op_bank(iss_idx[0]),
        .op_x(op_x), .op_m(op_m), .op_c(op_c),
        .req_vld(req_vld), .req_idx(req_idx)
    );

    cal_queue #(.NUM_CH(NUM_CH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .set_vld(req_vld), .set_idx(req_idx),
        .iss_vld(iss_vld), .iss_idx(iss_idx), .pend_any(pend_any)
    );

    cal_datapath #(.DW(DW), .CW(CW)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .iss_vld(iss_vld), .iss_ch(iss_idx[CW:1]), .iss_bank(iss_idx[0]),
        .op_x(op_x), .op_m(op_m), .op_c(op_c),
        .wb_vld(wb_vld), .wb_ch(wb_ch), .wb_bank(wb_bank), .wb_data(wb_data)
    );

    assign cal_a_w = st_q.cal_a;
    assign cal_b_w = st_q.cal_b;

    always_comb begin
        st_d = st_q;
        if (wb_vld) begin
            if (wb_bank) st_d.cal_b[wb_ch] = wb_data;
            else         st_d.cal_a[wb_ch] = wb_data;
        end
        if ({1'b0, rd_ch} < NCH)
            rd_data = rd_bank ? cal_b_w[rd_ch] : cal_a_w[rd_ch];
        else
            rd_data = '0;
        busy = pend_any | wb_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cal_a <= {NUM_CH{MID}};
            st_q.cal_b <= {NUM_CH{MID}};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cal_engine_chk.sv
module cal_engine_chk #(
    parameter int NUM_CH = 40,
    parameter int DW     = 14,
    localparam int CW    = $clog2(NUM_CH)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [CW-1:0]             wr_ch,
    input logic [1:0]                wr_sel,
    input logic                      busy,
    input logic                      iss_vld,
    input logic                      wb_vld,
    input logic                      wb_bank,
    input logic [NUM_CH-1:0][DW-1:0] cal_a_w,
    input logic [NUM_CH-1:0][DW-1:0] cal_b_w
);
    localparam logic [CW:0] NCH = NUM_CH[CW:0];

    logic ch_ok;
    assign ch_ok = ({1'b0, wr_ch} < NCH);

    // R5: a write-back is always preceded one cycle earlier by an issue
    assert_wb_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld |-> $past(iss_vld));

    // R6: an accepted trim write leaves the engine busy on the next cycle
    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel != 2'd3) && ch_ok) |=> busy);

    // R8: ignored or bank-bit writes on an idle engine queue nothing
    assert_ignored_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && ((wr_sel == 2'd3) || !ch_ok)) |=> !busy);

    // R9: results hold unless a write-back occurs
    assert_hold_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_vld |=> $stable(cal_a_w));
    assert_hold_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_vld |=> $stable(cal_b_w));

    // R3: a bank B write-back leaves every bank A result alone
    assert_bank_isolation_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && wb_bank) |=> $stable(cal_a_w));

endmodule

bind cal_engine cal_engine_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .busy(busy), .iss_vld(iss_vld), .wb_vld(wb_vld), .wb_bank(wb_bank),
    .cal_a_w(cal_a_w), .cal_b_w(cal_b_w)
);

// File: tb/tb_cal_engine.sv
`timescale 1ns/1ps
module tb_cal_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_ch = '0;
    logic [1:0]  wr_sel = '0;
    logic [13:0] wr_data = '0;
    logic [5:0]  rd_ch = '0;
    logic        rd_bank = 1'b0;
    logic [13:0] rd_data;
    logic        busy;

    int checks = 0;
    int errors = 0;

    cal_engine dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_ch(rd_ch),
        .rd_bank(rd_bank), .rd_data(rd_data), .busy(busy)
    );

    always #2 clk = ~clk;

    function automatic int model(input int x, input int m, input int c);
        int v;
        v = ((x * (m + 1)) >>> 14) + c - 8192;
        if (v < 0) v = 0;
        if (v > 16383) v = 16383;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hw(input int sel, input int ch, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_ch = 6'(ch); wr_data = 14'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int ch, input int bank, input int exp);
        rd_ch = 6'(ch); rd_bank = bank[0];
        #0.5;
        check(req, int'(rd_data), exp);
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        rd_chk("R1 ch0 A", 0, 0, 8192);
        rd_chk("R1 ch39 B", 39, 1, 8192);
        check("R1 busy", int'(busy), 0);
    endtask

    task automatic t_latency();
        hw(0, 2, 1000);
        check("R5 busy after k", int'(busy), 1);
        rd_chk("R5 old value after k", 2, 0, 8192);
        @(negedge clk);
        check("R5 busy after k+1", int'(busy), 1);
        rd_chk("R5 old value after k+1", 2, 0, 8192);
        @(negedge clk);
        rd_chk("R5 result after k+2", 2, 0, 1000);
        check("R5 idle after k+2", int'(busy), 0);
    endtask

    task automatic t_trim();
        hw(1, 2, 8191); wait_idle();
        rd_chk("R4 gain recalcs A", 2, 0, model(1000, 8191, 8192));
        rd_chk("R4 B untouched", 2, 1, 8192);
        hw(2, 2, 8292); wait_idle();
        rd_chk("R2 offset", 2, 0, 600);
        hw(1, 8, 4095); hw(0, 8, 12000); hw(2, 8, 8199); wait_idle();
        rd_chk("R2 scaled gain", 8, 0, 3007);
    endtask

    task automatic t_sat();
        hw(0, 6, 16383); hw(2, 6, 16383); wait_idle();
        rd_chk("R2 clamp high", 6, 0, 16383);
        hw(2, 7, 0); hw(0, 7, 100); wait_idle();
        rd_chk("R2 clamp low", 7, 0, 0);
    endtask

    task automatic t_bank();
        hw(3, 0, 1);
        hw(0, 2, 2000); wait_idle();
        rd_chk("R3 data to B", 2, 1, 1100);
        rd_chk("R3 A untouched", 2, 0, 600);
        hw(1, 2, 16383); wait_idle();
        rd_chk("R4 gain recalcs B", 2, 1, 2100);
        rd_chk("R4 A not recalculated", 2, 0, 600);
        hw(3, 0, 0);
    endtask

    task automatic t_burst();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 2'd0; wr_ch = 6'(10 + i); wr_data = 14'(500 + 37 * i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 busy during burst", int'(busy), 1);
        wait_idle();
        for (int i = 0; i < 10; i++)
            rd_chk("R6 burst result", 10 + i, 0, 500 + 37 * i);
        rd_chk("R9 neighbour unchanged", 20, 0, 8192);
        rd_chk("R9 other bank unchanged", 15, 1, 8192);
    endtask

    task automatic t_collision();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_ch = 6'd30; wr_data = 14'd3000;
        @(negedge clk);
        wr_data = 14'd4000;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        rd_chk("R7 stale result first", 30, 0, 3000);
        check("R7 rerun pending", int'(busy), 1);
        @(negedge clk);
        rd_chk("R7 newest after rerun", 30, 0, 4000);
        check("R7 idle after rerun", int'(busy), 0);
    endtask

    task automatic t_ignored();
        hw(0, 45, 1234);
        check("R8 out-of-range idle", int'(busy), 0);
        rd_chk("R8 ch5 A unchanged", 5, 0, 8192);
        rd_chk("R8 ch5 B unchanged", 5, 1, 8192);
        hw(3, 0, 0);
        check("R8 bank write idle", int'(busy), 0);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL R5 watchdog actual busy expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_trim();
        t_sat();
        t_bank();
        t_burst();
        t_collision();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule